// File: doc/BRIEF.md
# Single-Precision Round and Pack Unit

This unit takes an operand in unpacked form and emits its IEEE-754 single-precision encoding together with five status flags. The operand has a sign, a two-bit class, a signed unbiased exponent and a normalized 26-bit significand. The leading one sits at bit 25, bits 24..2 hold the 23 fraction bits, bit 1 is the guard bit and bit 0 is the round bit. A separate sticky input stands for any nonzero bits below those. The unit would sit at the tail of an arithmetic pipeline, after the normalizer, and it does the last step of every single-precision result.

For a number, the unit first checks whether the biased exponent falls at or below zero. If it does, the significand is shifted right to denormalize it, and any bits shifted out join the sticky term, so a single rounding step serves both normal and subnormal results. Rounding follows a two-bit mode input. The unit then checks for a carry out of the significand and for exponent overflow. Overflow is resolved either to infinity or to the largest finite magnitude. Zero, infinity and NaN bypass rounding. The result and flags are registered and appear one cycle after the input is presented.

Top module: `rp_round_pack`

## Requirements
- R1: While reset is low, and after it until the first accepted operand, `validOut` is 0, `resultOut` is 0 and all five flag outputs are 0.
- R2: Class code 01 is a number, with the leading one at `mantIn` bit 25, fraction in bits 24..2, guard in bit 1 and round in bit 0. When guard, round and `stickyIn` are all 0 the word is {sign, exponent+127, fraction} exactly and no flag is set.
- R3: When any of guard, round or sticky (including bits lost to denormalization) is 1, `inexactOut` and `fracInexactOut` are both 1.
- R4: Under mode 00 (nearest, ties to even) the kept significand is incremented only when guard is 1 and at least one of round, sticky or the kept least-significant bit is 1.
- R5: Mode 01 (toward zero) never increments. Mode 10 (toward plus infinity) increments an inexact value only when the sign is 0. Mode 11 (toward minus infinity) increments an inexact value only when the sign is 1.
- R6: `fracRoundedOut` is 1 exactly when the increment was applied.
- R7: When the increment carries a normal significand to 2.0, the exponent field is one higher and the fraction field is 0.
- R8: When exponent+127 is at most 0, the significand is shifted right by 1-(exponent+127) before rounding and packed with exponent field 0. If rounding reaches 2^-126, the output is exponent field 1 with fraction 0.
- R9: `underflowOut` is 1 when the packed result stays subnormal and either the rounding was inexact or `ufTrapEn` is 1.
- R10: When the exponent field after rounding would be 255 or more, the output is infinity with `overflowOut` = 1 under mode 00, under mode 10 for sign 0, and under mode 11 for sign 1. In every other case the output is exponent 254 with an all-ones fraction and `overflowOut` = 0.
- R11: Class 11 (NaN) gives exponent 255 with `mantIn` bits 24..2 as the fraction. Class 10 (infinity) gives exponent 255 with fraction 0. Class 00 (zero) gives only the sign bit. None of these sets a flag.
- R12: `validOut` equals `validIn` delayed by one clock. The result and flags load only when `validIn` is 1 and hold otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| validIn | input | 1 | Operand present this cycle |
| signIn | input | 1 | Operand sign |
| classIn | input | 2 | 00 zero, 01 number, 10 infinity, 11 NaN |
| expIn | input | 10 | Signed unbiased exponent |
| mantIn | input | 26 | Significand with guard and round bits |
| stickyIn | input | 1 | OR of the bits below round |
| rmodeIn | input | 2 | Rounding mode |
| ufTrapEn | input | 1 | Underflow trap enable |
| validOut | output | 1 | Result valid |
| resultOut | output | 32 | Packed single-precision word |
| inexactOut | output | 1 | Inexact |
| fracInexactOut | output | 1 | Fraction inexact |
| fracRoundedOut | output | 1 | Fraction rounded up |
| overflowOut | output | 1 | Overflow to infinity |
| underflowOut | output | 1 | Underflow |

## Verification
The assertions hold on every cycle for properties that do not depend on data values. They check that valid follows its input by exactly one cycle. They check that a rounded-up flag never appears without inexact, that overflow always comes with an infinity encoding, and that underflow always comes with a zero exponent field. They also check that the toward-zero mode, and the toward-plus-infinity mode on negative operands, never increment. Only the bench scenarios can show that the packed bits are correct. These cover ties to even in both directions, the carry into the exponent, subnormals that round up to the smallest normal, very deep denormalization, and the choice between infinity and the largest finite value for each mode and sign.

// File: rtl/rp_pkg.sv
package rp_pkg;
  parameter int FRAC_W   = 23;
  parameter int EXP_W    = 8;
  parameter int EXP_IN_W = 10;
  localparam int MANT_W  = FRAC_W + 3;
  localparam int WORD_W  = 1 + EXP_W + FRAC_W;
  localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
  localparam int EXP_MAX = (1 << EXP_W) - 1;
  localparam int SH_CAP  = MANT_W + 1;
  localparam int SH_W    = $clog2(SH_CAP + 1);

  typedef enum logic [1:0] {CLS_ZERO = 2'b00, CLS_NUM = 2'b01, CLS_INF = 2'b10, CLS_NAN = 2'b11} cls_e;
  typedef enum logic [1:0] {RM_NEAR = 2'b00, RM_ZERO = 2'b01, RM_UP = 2'b10, RM_DOWN = 2'b11} rm_e;

  typedef struct packed {
    logic                       isZero;
    logic                       isInf;
    logic                       isNan;
    logic                       isSub;
    logic [SH_W-1:0]            shAmt;
    logic signed [EXP_IN_W:0]   biasedExp;
  } strobe_t;
endpackage

// File: rtl/rp_ctrl.sv
module rp_ctrl
  import rp_pkg::*;
(
  input  logic [1:0]                 classIn,
  input  logic signed [EXP_IN_W-1:0] expIn,
  output strobe_t                    strobes
);
  localparam logic signed [EXP_IN_W:0] BIAS_X = BIAS;
  localparam logic signed [EXP_IN_W:0] ONE_X  = 1;
  localparam logic signed [EXP_IN_W:0] CAP_X  = SH_CAP;

  logic signed [EXP_IN_W:0] biased;
  logic signed [EXP_IN_W:0] underAmt;
  logic                     isNum;

  always_comb begin
    biased   = $signed({expIn[EXP_IN_W-1], expIn}) + BIAS_X;
    underAmt = ONE_X - biased;
    isNum    = (classIn == CLS_NUM);

    strobes.isZero    = (classIn == CLS_ZERO);
    strobes.isInf     = (classIn == CLS_INF);
    strobes.isNan     = (classIn == CLS_NAN);
    strobes.isSub     = isNum && (biased <= 0);
    strobes.biasedExp = biased;
    if (!strobes.isSub)
      strobes.shAmt = '0;
    else if (underAmt > CAP_X)
      strobes.shAmt = CAP_X[SH_W-1:0];
    else
      strobes.shAmt = underAmt[SH_W-1:0];
  end
endmodule

// File: rtl/rp_dpath.sv
module rp_dpath
  import rp_pkg::*;
(
  input  strobe_t             st,
  input  logic                signIn,
  input  logic [MANT_W-1:0]   mantIn,
  input  logic                stickyIn,
  input  logic [1:0]          rmode,
  input  logic                ufTrapEn,
  output logic [WORD_W-1:0]   result,
  output logic                ixFlag,
  output logic                frFlag,
  output logic                ofFlag,
  output logic                ufFlag
);
  localparam logic signed [EXP_IN_W:0] EXP_MAX_X = EXP_MAX;
  localparam logic [EXP_W-1:0]  EXP_ONES = '1;
  localparam logic [EXP_W-1:0]  EXP_TOP  = EXP_ONES - 1'b1;
  localparam logic [EXP_W-1:0]  EXP_MIN  = 1;
  localparam logic [FRAC_W-1:0] FRAC_Z   = '0;
  localparam logic [FRAC_W-1:0] FRAC_ONES = '1;

  logic [2*MANT_W-1:0]      sExt;
  logic [MANT_W-1:0]        aligned;
  logic [FRAC_W:0]          kept;
  logic [FRAC_W+1:0]        rounded;
  logic                     guardB, roundB, stk, inexact, incr, carry, toInf;
  logic signed [EXP_IN_W:0] expAdj;

  // alignment and rounding decision
  always_comb begin
    sExt    = {mantIn, {MANT_W{1'b0}}} >> st.shAmt;
    aligned = sExt[2*MANT_W-1:MANT_W];
    guardB  = aligned[1];
    roundB  = aligned[0];
    stk     = stickyIn | (|sExt[MANT_W-1:0]);
    kept    = aligned[MANT_W-1:2];
    inexact = guardB | roundB | stk;
    unique case (rmode)
      RM_NEAR: incr = guardB & (roundB | stk | kept[0]);
      RM_ZERO: incr = 1'b0;
      RM_UP:   incr = inexact & ~signIn;
      default: incr = inexact & signIn;
    endcase
    unique case (rmode)
      RM_NEAR: toInf = 1'b1;
      RM_ZERO: toInf = 1'b0;
      RM_UP:   toInf = ~signIn;
      default: toInf = signIn;
    endcase
    rounded = {1'b0, kept} + {{(FRAC_W+1){1'b0}}, incr};
    carry   = rounded[FRAC_W+1];
    expAdj  = st.biasedExp + $signed({{EXP_IN_W{1'b0}}, carry});
  end

  // R5
  always_comb begin
    rz_no_incr_chk: assert (!(rmode == RM_ZERO && incr));
  end

  // R5
  always_comb begin
    rp_neg_no_incr_chk: assert (!(rmode == RM_UP && signIn && incr));
  end

  // packing
  always_comb begin
    result = '0;
    ixFlag = 1'b0;
    frFlag = 1'b0;
    ofFlag = 1'b0;
    ufFlag = 1'b0;
    if (st.isNan) begin
      result = {signIn, EXP_ONES, mantIn[MANT_W-2:2]};
    end else if (st.isInf) begin
      result = {signIn, EXP_ONES, FRAC_Z};
    end else if (st.isZero) begin
      result = {signIn, {(WORD_W-1){1'b0}}};
    end else begin
      ixFlag = inexact;
      frFlag = incr;
      if (st.isSub) begin
        if (rounded[FRAC_W])
          result = {signIn, EXP_MIN, FRAC_Z};
        else
          result = {signIn, {EXP_W{1'b0}}, rounded[FRAC_W-1:0]};
        ufFlag = ~rounded[FRAC_W] & (inexact | ufTrapEn);
      end else if (expAdj >= EXP_MAX_X) begin
        if (toInf) begin
          result = {signIn, EXP_ONES, FRAC_Z};
          ofFlag = 1'b1;
        end else begin
          result = {signIn, EXP_TOP, FRAC_ONES};
        end
      end else begin
        result = {signIn, expAdj[EXP_W-1:0], rounded[FRAC_W-1:0]};
      end
    end
  end
endmodule

// File: rtl/rp_round_pack.sv
module rp_round_pack
  import rp_pkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        validIn,
  input  logic                        signIn,
  input  logic [1:0]                  classIn,
  input  logic [EXP_IN_W-1:0]         expIn,
  input  logic [MANT_W-1:0]           mantIn,
  input  logic                        stickyIn,
  input  logic [1:0]                  rmodeIn,
  input  logic                        ufTrapEn,
  output logic                        validOut,
  output logic [WORD_W-1:0]           resultOut,
  output logic                        inexactOut,
  output logic                        fracInexactOut,
  output logic                        fracRoundedOut,
  output logic                        overflowOut,
  output logic                        underflowOut
);
  strobe_t           strobes;
  logic [WORD_W-1:0] resultD;
  logic              ixD, frD, ofD, ufD;

  rp_ctrl uCtrl (
    .classIn (classIn),
    .expIn   ($signed(expIn)),
    .strobes (strobes)
  );

  rp_dpath uDpath (
    .st       (strobes),
    .signIn   (signIn),
    .mantIn   (mantIn),
    .stickyIn (stickyIn),
    .rmode    (rmodeIn),
    .ufTrapEn (ufTrapEn),
    .result   (resultD),
    .ixFlag   (ixD),
    .frFlag   (frD),
    .ofFlag   (ofD),
    .ufFlag   (ufD)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validOut       <= 1'b0;
      resultOut      <= '0;
      inexactOut     <= 1'b0;
      fracInexactOut <= 1'b0;
      fracRoundedOut <= 1'b0;
      overflowOut    <= 1'b0;
      underflowOut   <= 1'b0;
    end else begin
      validOut <= validIn;
      if (validIn) begin
        resultOut      <= resultD;
        inexactOut     <= ixD;
        fracInexactOut <= ixD;
        fracRoundedOut <= frD;
        overflowOut    <= ofD;
        underflowOut   <= ufD;
      end
    end
  end

  // R12
  valid_rise_chk: assert property (@(posedge clk) disable iff (!rstN) validIn |=> validOut);
  // R12
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rstN) !validIn |=> !validOut);
  // R12
  hold_chk: assert property (@(posedge clk) disable iff (!rstN) !validIn |=> $stable(resultOut));
  // R6
  fr_needs_ix_chk: assert property (@(posedge clk) disable iff (!rstN) fracRoundedOut |-> inexactOut);
  // R10
  ovf_inf_chk: assert property (@(posedge clk) disable iff (!rstN)
    overflowOut |-> (resultOut[WORD_W-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}}));
  // R9
  uf_sub_chk: assert property (@(posedge clk) disable iff (!rstN)
    underflowOut |-> (resultOut[WORD_W-2:FRAC_W] == '0));
endmodule

// File: tb/tb_rp_round_pack.sv
module tb_rp_round_pack;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        validIn = 1'b0, signIn = 1'b0, stickyIn = 1'b0, ufTrapEn = 1'b0;
  logic [1:0]  classIn = 2'b00, rmodeIn = 2'b00;
  logic [9:0]  expIn = '0;
  logic [25:0] mantIn = '0;
  logic        validOut, inexactOut, fracInexactOut, fracRoundedOut, overflowOut, underflowOut;
  logic [31:0] resultOut;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  typedef struct {
    bit [31:0] res;
    bit ix, fr, of, uf;
    string tag;
  } exp_t;

  exp_t pending[$];

  always #2 clk = ~clk;

  rp_round_pack dut (
    .clk(clk), .rstN(rstN), .validIn(validIn), .signIn(signIn), .classIn(classIn),
    .expIn(expIn), .mantIn(mantIn), .stickyIn(stickyIn), .rmodeIn(rmodeIn),
    .ufTrapEn(ufTrapEn), .validOut(validOut), .resultOut(resultOut),
    .inexactOut(inexactOut), .fracInexactOut(fracInexactOut),
    .fracRoundedOut(fracRoundedOut), .overflowOut(overflowOut), .underflowOut(underflowOut)
  );

  function automatic exp_t refModel(bit s, bit [1:0] c, int e, int m, bit st, bit [1:0] rm, bit tr);
    exp_t x;
    int be, k, n, ex;
    bit g, r, stk, ix, up, inf;
    bit [31:0] sb;
    x.res = 0; x.ix = 0; x.fr = 0; x.of = 0; x.uf = 0; x.tag = "";
    sb = s ? 32'h8000_0000 : 32'h0;
    if (c == 2'b00) begin x.res = sb; return x; end
    if (c == 2'b10) begin x.res = sb | 32'h7F80_0000; return x; end
    if (c == 2'b11) begin x.res = sb | 32'h7F80_0000 | ((m >> 2) & 32'h007F_FFFF); return x; end
    be = e + 127;
    stk = st;
    if (be <= 0) begin
      n = 1 - be;
      for (int i = 0; i < n && i < 40; i++) begin
        if (m & 1) stk = 1;
        m = m >> 1;
      end
    end
    g = (m >> 1) & 1;
    r = m & 1;
    k = m >> 2;
    ix = g | r | stk;
    case (rm)
      2'b00: up = g && (r || stk || (k & 1));
      2'b01: up = 0;
      2'b10: up = ix && !s;
      default: up = ix && s;
    endcase
    case (rm)
      2'b00: inf = 1;
      2'b01: inf = 0;
      2'b10: inf = !s;
      default: inf = s;
    endcase
    k = k + (up ? 1 : 0);
    x.ix = ix; x.fr = up;
    if (be <= 0) begin
      if (k >= 32'h0080_0000) x.res = sb | 32'h0080_0000;
      else begin
        x.res = sb | k;
        x.uf = ix || tr;
      end
    end else begin
      ex = be;
      if (k >= 32'h0100_0000) ex = ex + 1;
      if (ex >= 255) begin
        if (inf) begin x.res = sb | 32'h7F80_0000; x.of = 1; end
        else x.res = sb | 32'h7F7F_FFFF;
      end else x.res = sb | (ex << 23) | (k & 32'h007F_FFFF);
    end
    return x;
  endfunction

  task automatic apply(string tag, bit s, bit [1:0] c, int e, int m, bit st, bit [1:0] rm, bit tr);
    exp_t x;
    @(negedge clk);
    validIn = 1; signIn = s; classIn = c; expIn = 10'(e); mantIn = 26'(m);
    stickyIn = st; rmodeIn = rm; ufTrapEn = tr;
    x = refModel(s, c, e, m, st, rm, tr);
    x.tag = tag;
    pending.push_back(x);
    @(negedge clk);
    validIn = 0;
  endtask

  // per-cycle comparison against the model queue
  always @(posedge clk) begin
    #1;
    if (rstN && !done) begin
      if (pending.size() > 0) begin
        exp_t x;
        x = pending.pop_front();
        checks++;
        if (!validOut || resultOut !== x.res || inexactOut !== x.ix || fracInexactOut !== x.ix ||
            fracRoundedOut !== x.fr || overflowOut !== x.of || underflowOut !== x.uf) begin
          errors++;
          $display("FAIL %s: got v=%0b res=%08h ix=%0b fi=%0b fr=%0b of=%0b uf=%0b exp v=1 res=%08h ix=%0b fi=%0b fr=%0b of=%0b uf=%0b",
                   x.tag, validOut, resultOut, inexactOut, fracInexactOut, fracRoundedOut,
                   overflowOut, underflowOut, x.res, x.ix, x.ix, x.fr, x.of, x.uf);
        end
      end else if (validOut) begin
        checks++;
        errors++;
        $display("FAIL R12: validOut=1 expected 0");
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 50000) begin @(posedge clk); cyc++; end
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run incomplete got %0d cycles expected finish", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    repeat (3) @(posedge clk);
    #1;
    checks++;
    // R1 reset state
    if (validOut !== 0 || resultOut !== 0 || inexactOut || fracInexactOut || fracRoundedOut || overflowOut || underflowOut) begin
      errors++;
      $display("FAIL R1: got v=%0b res=%08h expected v=0 res=00000000", validOut, resultOut);
    end
    @(negedge clk);
    rstN = 1;
    @(negedge clk);
    checks++;
    if (validOut !== 0 || resultOut !== 0) begin
      errors++;
      $display("FAIL R1: after release got v=%0b res=%08h expected 0 00000000", validOut, resultOut);
    end

    apply("R2 exact one",            0, 2'b01, 0,    'h2000000, 0, 2'b00, 0);
    apply("R2 exact negative",       1, 2'b01, 5,    'h2ABCDE0, 0, 2'b01, 0);
    apply("R3 sticky only",          0, 2'b01, 3,    'h2000000, 1, 2'b01, 0);
    apply("R4 tie even down",        0, 2'b01, 0,    'h2000002, 0, 2'b00, 0);
    apply("R4 tie odd up",           0, 2'b01, 0,    'h2000006, 0, 2'b00, 0);
    apply("R4 guard with sticky",    0, 2'b01, 0,    'h2000002, 1, 2'b00, 0);
    apply("R4 round only no incr",   1, 2'b01, 0,    'h2000001, 1, 2'b00, 0);
    apply("R5 toward zero",          0, 2'b01, 0,    'h2000003, 1, 2'b01, 0);
    apply("R5 plus inf positive",    0, 2'b01, 0,    'h2000001, 0, 2'b10, 0);
    apply("R5 plus inf negative",    1, 2'b01, 0,    'h2000001, 0, 2'b10, 0);
    apply("R5 minus inf negative",   1, 2'b01, 0,    'h2000001, 0, 2'b11, 0);
    apply("R6 minus inf positive",   0, 2'b01, 0,    'h2000003, 0, 2'b11, 0);
    apply("R7 carry to two",         0, 2'b01, 4,    'h3FFFFFE, 0, 2'b00, 0);
    apply("R8 subnormal shift one",  0, 2'b01, -127, 'h2000004, 0, 2'b01, 0);
    apply("R8 round to min normal",  0, 2'b01, -127, 'h3FFFFFF, 0, 2'b00, 0);
    apply("R8 deep denorm plus",     0, 2'b01, -200, 'h2000000, 0, 2'b10, 0);
    apply("R9 deep denorm zero",     1, 2'b01, -200, 'h2000000, 0, 2'b00, 0);
    apply("R9 exact sub trap",       0, 2'b01, -127, 'h2000000, 0, 2'b00, 1);
    apply("R9 exact sub no trap",    0, 2'b01, -127, 'h2000000, 0, 2'b00, 0);
    apply("R10 nearest to inf",      0, 2'b01, 128,  'h2000000, 0, 2'b00, 0);
    apply("R10 zero mode max",       1, 2'b01, 128,  'h2000000, 0, 2'b01, 0);
    apply("R10 plus neg max",        1, 2'b01, 200,  'h2000000, 0, 2'b10, 0);
    apply("R10 minus neg inf",       1, 2'b01, 130,  'h2000000, 0, 2'b11, 0);
    apply("R10 round into inf",      0, 2'b01, 127,  'h3FFFFFE, 0, 2'b00, 0);
    apply("R10 largest exact",       0, 2'b01, 127,  'h3FFFFFC, 0, 2'b00, 0);
    apply("R11 nan payload",         1, 2'b11, 0,    'h3555554, 1, 2'b10, 1);
    apply("R11 infinity",            1, 2'b10, 0,    'h2000007, 1, 2'b00, 0);
    apply("R11 zero",                1, 2'b00, 0,    'h0000003, 1, 2'b10, 1);

    // R12 hold while idle
    apply("R12 load", 0, 2'b01, 1, 'h2123458, 0, 2'b00, 0);
    held = resultOut;
    @(negedge clk);
    signIn = 1; expIn = 10'(50); mantIn = 26'h3FFFFFF;
    @(negedge clk);
    checks++;
    if (validOut !== 0 || resultOut !== held) begin
      errors++;
      $display("FAIL R12: idle got v=%0b res=%08h expected v=0 res=%08h", validOut, resultOut, held);
    end

    // back-to-back random operands
    for (int i = 0; i < 300; i++) begin
      exp_t x;
      int e, m;
      bit s, st, tr;
      bit [1:0] rm, c;
      @(negedge clk);
      s  = 1'($urandom);
      st = 1'($urandom);
      tr = 1'($urandom);
      rm = 2'($urandom);
      c  = ($urandom % 8 == 0) ? 2'($urandom) : 2'b01;
      e  = int'($urandom % 320) - 170;
      m  = int'($urandom & 32'h01FF_FFFF) | 'h2000000;
      validIn = 1; signIn = s; classIn = c; expIn = 10'(e); mantIn = 26'(m);
      stickyIn = st; rmodeIn = rm; ufTrapEn = tr;
      x = refModel(s, c, e, m, st, rm, tr);
      x.tag = "R4 R5 R8 R10 random";
      pending.push_back(x);
    end
    @(negedge clk);
    validIn = 0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule